// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Dispatcher

This block holds the per-function interrupt vector table and the pending-bit array of a message-signalled interrupt function. Both sit in one 4 KiB memory-mapped window, which software reaches through a simple register port that takes 32-bit words. Device logic drives one request level per vector. A rising level makes that vector pending. A single dispatcher then turns pending vectors into 64-bit-address, 32-bit-data message writes on a valid/ready output toward the host interface.

Delivery is gated by three things: a function enable, a function-wide mask and a mask bit in each vector's control word. While a vector is blocked, its pending bit stays set. When the block is lifted, the vector is delivered. The block can be lifted by clearing the mask bit through a table write, by dropping the function mask, or by raising the enable. The dispatcher scans eligible vectors from the lowest index up and sends one message per accepted handshake. The configuration-space decode that produces the enable and mask inputs lies outside this block.

Top module: `msix_vector_unit`

## Requirements
- R1: After reset every table word and every pending bit reads as zero, the message output is not valid, and the read data is zero.
- R2: Vector N's entry starts at window offset N*16. Its four words, at offsets +0, +4, +8 and +12, are: address low, address high, message data, vector control. A full-word write is read back unchanged. The read data is valid one cycle after the read request.
- R3: Only accesses with byte strobe 4'b1111 act. A write with any other strobe changes nothing, and a read with any other strobe returns zero.
- R4: A read at offset 0x800 + 4*K returns pending bits 32*K+31 down to 32*K. Vector N's bit sits at bit (N mod 8) of byte 0x800 + N/8. Bits beyond the implemented vector count read as zero. Writes at offsets 0x800 and above are ignored.
- R5: A low-to-high transition of a request level sets that vector's pending bit. A level that stays high or stays low does not set it.
- R6: A message carries the address {address high, address low with bits [1:0] forced to zero} and the entry's message data word.
- R7: No message is sent while the enable is low, while the function mask is high, or for a vector whose control bit 0 is 1. In all of these cases the pending bit stays set.
- R8: A pending vector is delivered once it becomes unmasked. This happens when a table write clears its control bit 0, when the function mask falls, or when the enable rises.
- R9: Eligible pending vectors are sent one at a time, lowest index first. A vector's pending bit is cleared in the cycle its message is accepted.
- R10: Once the message output is valid, it stays valid with the same address and data until ready is high.
- R11: Table offsets that belong to vectors at or above the implemented count read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_enable | input | 1 | Function-level interrupt enable |
| fn_mask | input | 1 | Function-wide mask |
| mmio_wr_en | input | 1 | Register write request |
| mmio_rd_en | input | 1 | Register read request |
| mmio_addr | input | 12 | Byte offset in the window |
| mmio_strb | input | 4 | Byte strobes; only 4'b1111 acts |
| mmio_wdata | input | 32 | Write data |
| mmio_rdata | output | 32 | Read data, one cycle after the request |
| mmio_rvalid | output | 1 | Read data valid |
| irq_lvl | input | NUM_VEC | Per-vector request levels |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message accepted by host side |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Properties are checked on every cycle. They cover: a held message keeps its payload until it is accepted; the message address is always word-aligned; a message can only start while the function is enabled and unmasked; a pending bit is only cleared while it is set; read data follows its read request. Other behaviour can only be shown by bench scenarios. These are the word layout, strobe filtering, pending readback and the ignoring of writes to the pending area, edge-only triggering, ascending delivery order, and re-delivery after each of the three ways of unmasking.

// File: rtl/msix_pkg.sv
// Shared definitions for the vector table unit: word selectors inside a
// table entry and the window split between table and pending area.
package msix_pkg;
    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } entry_word_e;

    // Window offset bit that selects the pending area (offset 0x800 and up).
    localparam int PEND_AREA_BIT = 11;
    // Bit of the control word that masks the vector.
    localparam int CTRL_MASK_BIT = 0;
endpackage

// File: rtl/msix_table_regs.sv
// Vector table storage and register access.
// Holds four 32-bit words per vector and serves full-word reads and writes
// from the register port. It also returns the pending bits for reads in the
// pending area. Assumes NUM_VEC <= 128, so that the table fits below 0x800.
// Reads take one cycle. Accesses without a full strobe are dropped.
module msix_table_regs
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [11:0]               addr,
    input  logic [3:0]                strb,
    input  logic [31:0]               wdata,
    input  logic [NUM_VEC-1:0]        pend,
    output logic [31:0]               rdata,
    output logic                      rvalid,
    output logic [NUM_VEC-1:0][31:0]  tbl_lo,
    output logic [NUM_VEC-1:0][31:0]  tbl_hi,
    output logic [NUM_VEC-1:0][31:0]  tbl_data,
    output logic [NUM_VEC-1:0]        vmask
);
    localparam int PEND_WORDS = (NUM_VEC + 31) / 32;
    localparam int PEND_PAD   = PEND_WORDS * 32;

    logic [NUM_VEC-1:0][31:0] tbl_ctrl;
    logic                     full_word;
    logic                     in_pend;
    logic [6:0]               vec_sel;
    entry_word_e              word_sel;
    logic [8:0]               pword_sel;
    logic [PEND_PAD-1:0]      pend_pad;
    logic [31:0]              rd_tbl;
    logic [31:0]              rd_pend;

    assign full_word = (strb == 4'b1111);
    assign in_pend   = addr[PEND_AREA_BIT];
    assign vec_sel   = addr[10:4];
    assign word_sel  = entry_word_e'(addr[3:2]);
    assign pword_sel = addr[10:2];
    assign pend_pad  = PEND_PAD'(pend);

    // Table word storage, written only by full-word writes to implemented entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_lo   <= '0;
            tbl_hi   <= '0;
            tbl_data <= '0;
            tbl_ctrl <= '0;
        end else if (wr_en && full_word && !in_pend) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (vec_sel == 7'(v)) begin
                    case (word_sel)
                        W_ADDR_LO: tbl_lo[v]   <= wdata;
                        W_ADDR_HI: tbl_hi[v]   <= wdata;
                        W_DATA:    tbl_data[v] <= wdata;
                        default:   tbl_ctrl[v] <= wdata;
                    endcase
                end
            end
        end
    end

    // Per-vector mask bits taken from the control words.
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) vmask[v] = tbl_ctrl[v][CTRL_MASK_BIT];
    end

    // Table read mux; unimplemented entries give zero.
    always_comb begin
        rd_tbl = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (vec_sel == 7'(v)) begin
                case (word_sel)
                    W_ADDR_LO: rd_tbl = tbl_lo[v];
                    W_ADDR_HI: rd_tbl = tbl_hi[v];
                    W_DATA:    rd_tbl = tbl_data[v];
                    default:   rd_tbl = tbl_ctrl[v];
                endcase
            end
        end
    end

    // Pending area read mux; words past the implemented bits give zero.
    always_comb begin
        rd_pend = '0;
        for (int k = 0; k < PEND_WORDS; k++) begin
            if (pword_sel == 9'(k)) rd_pend = pend_pad[k*32 +: 32];
        end
    end

    // Registered read data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= !full_word ? 32'd0 : (in_pend ? rd_pend : rd_tbl);
        end
    end

    AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en)); // R2
endmodule

// File: rtl/msix_pend_bits.sv
// Pending-bit array.
// Detects rising request levels and sets the matching pending bits. It
// clears a bit when the dispatcher reports the acceptance of that vector's
// message. A set in the same cycle as a clear wins, so a new edge is kept.
module msix_pend_bits #(
    parameter int NUM_VEC = 8,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_lvl,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_VEC-1:0] pend
);
    logic [NUM_VEC-1:0] lvl_q;
    logic [NUM_VEC-1:0] rise;
    logic [NUM_VEC-1:0] clr_vec;

    assign rise = irq_lvl & ~lvl_q;

    // One-hot clear vector from the accepted message index.
    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) clr_vec[i] = clr_en && (clr_idx == IDX_W'(i));
    end

    // Level history and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            pend  <= '0;
        end else begin
            lvl_q <= irq_lvl;
            pend  <= (pend & ~clr_vec) | rise;
        end
    end

    AST_CLEAR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> |(pend & clr_vec)); // R9
endmodule

// File: rtl/msix_dispatch.sv
// Message dispatcher.
// Picks the lowest-index vector that is pending, not masked per vector, and
// allowed by the function enable and mask. It latches that vector's address
// and data into the output register and holds them until ready. Acceptance
// is reported back so that the pending bit can be cleared. A held message
// is not withdrawn if the vector is masked while it waits.
module msix_dispatch #(
    parameter int NUM_VEC = 8,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fn_enable,
    input  logic                     fn_mask,
    input  logic [NUM_VEC-1:0]       pend,
    input  logic [NUM_VEC-1:0]       vmask,
    input  logic [NUM_VEC-1:0][31:0] tbl_lo,
    input  logic [NUM_VEC-1:0][31:0] tbl_hi,
    input  logic [NUM_VEC-1:0][31:0] tbl_data,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [63:0]              msg_addr,
    output logic [31:0]              msg_data,
    output logic                     clr_en,
    output logic [IDX_W-1:0]         clr_idx
);
    logic [NUM_VEC-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   sel;
    logic [IDX_W-1:0]   idx_q;

    assign elig = pend & ~vmask & {NUM_VEC{fn_enable & ~fn_mask}};

    // Lowest-index priority pick among eligible vectors.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (elig[i] && !found) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    // Output register: load when idle, release on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            idx_q     <= '0;
        end else if (msg_valid) begin
            if (msg_ready) msg_valid <= 1'b0;
        end else if (found) begin
            msg_valid <= 1'b1;
            msg_addr  <= {tbl_hi[sel], tbl_lo[sel][31:2], 2'b00};
            msg_data  <= tbl_data[sel];
            idx_q     <= sel;
        end
    end

    assign clr_en  = msg_valid && msg_ready;
    assign clr_idx = idx_q;

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[1:0] == 2'b00)); // R6
    AST_SEND_WHEN_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(fn_enable && !fn_mask)); // R7
endmodule

// File: rtl/msix_vector_unit.sv
// Top of the message-signalled interrupt vector unit.
// Connects the table registers, the pending array and the dispatcher.
// Assumes that the enable and mask inputs come from configuration-space logic
// outside the block, and that 1 <= NUM_VEC <= 128.
module msix_vector_unit #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fn_enable,
    input  logic               fn_mask,
    input  logic               mmio_wr_en,
    input  logic               mmio_rd_en,
    input  logic [11:0]        mmio_addr,
    input  logic [3:0]         mmio_strb,
    input  logic [31:0]        mmio_wdata,
    output logic [31:0]        mmio_rdata,
    output logic               mmio_rvalid,
    input  logic [NUM_VEC-1:0] irq_lvl,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [NUM_VEC-1:0][31:0] tbl_lo;
    logic [NUM_VEC-1:0][31:0] tbl_hi;
    logic [NUM_VEC-1:0][31:0] tbl_data;
    logic [NUM_VEC-1:0]       vmask;
    logic [NUM_VEC-1:0]       pend;
    logic                     clr_en;
    logic [IDX_W-1:0]         clr_idx;

    msix_table_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mmio_wr_en), .rd_en(mmio_rd_en), .addr(mmio_addr),
        .strb(mmio_strb), .wdata(mmio_wdata), .pend(pend),
        .rdata(mmio_rdata), .rvalid(mmio_rvalid),
        .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .tbl_data(tbl_data), .vmask(vmask)
    );

    msix_pend_bits #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl),
        .clr_en(clr_en), .clr_idx(clr_idx), .pend(pend)
    );

    msix_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
        .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable), .fn_mask(fn_mask),
        .pend(pend), .vmask(vmask),
        .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .tbl_data(tbl_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );
endmodule

// File: tb/test_msix_vector_unit.sv
module test_msix_vector_unit;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fn_enable = 1'b0;
    logic          fn_mask = 1'b0;
    logic          mmio_wr_en = 1'b0;
    logic          mmio_rd_en = 1'b0;
    logic [11:0]   mmio_addr = '0;
    logic [3:0]    mmio_strb = '0;
    logic [31:0]   mmio_wdata = '0;
    logic [31:0]   mmio_rdata;
    logic          mmio_rvalid;
    logic [NV-1:0] irq_lvl = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    msix_vector_unit #(.NUM_VEC(NV)) i_msix_vector_unit (
        .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable), .fn_mask(fn_mask),
        .mmio_wr_en(mmio_wr_en), .mmio_rd_en(mmio_rd_en), .mmio_addr(mmio_addr),
        .mmio_strb(mmio_strb), .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata),
        .mmio_rvalid(mmio_rvalid), .irq_lvl(irq_lvl), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] exp_lo(int n);
        return 32'hA000_0000 + 32'(n * 16) + 32'd3;
    endfunction
    function automatic logic [31:0] exp_hi(int n);
        return 32'h0000_0100 + 32'(n);
    endfunction
    function automatic logic [31:0] exp_dat(int n);
        return 32'hD00D_0000 + 32'(n * 7);
    endfunction
    function automatic logic [63:0] exp_msg_addr(int n);
        return {exp_hi(n), exp_lo(n) & 32'hFFFF_FFFC};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        mmio_wr_en = 1'b1; mmio_addr = a; mmio_wdata = d; mmio_strb = s;
        @(negedge clk);
        mmio_wr_en = 1'b0; mmio_strb = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        mmio_rd_en = 1'b1; mmio_addr = a; mmio_strb = s;
        @(negedge clk);
        mmio_rd_en = 1'b0; mmio_strb = '0;
        d = mmio_rdata;
        n_chk = n_chk + 1;
        if (mmio_rvalid !== 1'b1) begin
            n_bad = n_bad + 1;
            $display("FAIL R2 rvalid: actual %b expected 1", mmio_rvalid);
        end
    endtask

    task automatic no_msg(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(req, 64'(msg_valid), 64'd0);
        end
    endtask

    // Wait for a message, check payload and hold, then accept it.
    task automatic take_msg(input int n, input string req);
        int waited = 0;
        @(negedge clk);
        while (!msg_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk({req, " valid"}, 64'(msg_valid), 64'd1);
        chk({req, " R6 addr"}, msg_addr, exp_msg_addr(n));
        chk({req, " R6 data"}, 64'(msg_data), 64'(exp_dat(n)));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10 hold", {63'd0, msg_valid} + (msg_addr ^ exp_msg_addr(n)), 64'd1);
        end
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 msg_valid", 64'(msg_valid), 64'd0);
        chk("R1 rdata", 64'(mmio_rdata), 64'd0);
        for (int a = 0; a < NV * 4; a++) begin
            rd(12'(a * 4), 4'hF, d);
            chk("R1 table zero", 64'(d), 64'd0);
        end
        rd(12'h800, 4'hF, d);
        chk("R1 pending zero", 64'(d), 64'd0);

        // R2: fill the table and read it back
        for (int n = 0; n < NV; n++) begin
            wr(12'(n * 16 + 0), exp_lo(n), 4'hF);
            wr(12'(n * 16 + 4), exp_hi(n), 4'hF);
            wr(12'(n * 16 + 8), exp_dat(n), 4'hF);
            wr(12'(n * 16 + 12), 32'h0, 4'hF);
        end
        for (int n = 0; n < NV; n++) begin
            rd(12'(n * 16 + 0), 4'hF, d); chk("R2 addr low", 64'(d), 64'(exp_lo(n)));
            rd(12'(n * 16 + 4), 4'hF, d); chk("R2 addr high", 64'(d), 64'(exp_hi(n)));
            rd(12'(n * 16 + 8), 4'hF, d); chk("R2 data", 64'(d), 64'(exp_dat(n)));
        end

        // R3: partial strobes
        wr(12'h008, 32'hFFFF_FFFF, 4'b0011);
        rd(12'h008, 4'hF, d); chk("R3 partial write ignored", 64'(d), 64'(exp_dat(0)));
        rd(12'h008, 4'b0111, d); chk("R3 partial read zero", 64'(d), 64'd0);

        // R11: entry beyond implemented count
        wr(12'(NV * 16), 32'h1234_5678, 4'hF);
        rd(12'(NV * 16), 4'hF, d); chk("R11 unimplemented entry", 64'(d), 64'd0);

        // R5/R7: rising levels with enable low set pending, no messages
        @(negedge clk); irq_lvl = '1;
        no_msg("R7 disabled", 6);
        rd(12'h800, 4'hF, d); chk("R5 R4 pending set", 64'(d), 64'hFF);
        wr(12'h800, 32'h0, 4'hF);
        rd(12'h800, 4'hF, d); chk("R4 pending write ignored", 64'(d), 64'hFF);
        rd(12'h804, 4'hF, d); chk("R4 pending beyond count", 64'(d), 64'd0);

        // R7: per-vector mask on vector 2, function mask on
        wr(12'(2 * 16 + 12), 32'h1, 4'hF);
        @(negedge clk); fn_mask = 1'b1; fn_enable = 1'b1;
        no_msg("R7 function mask", 6);
        rd(12'h800, 4'hF, d); chk("R7 pending kept", 64'(d), 64'hFF);

        // R8/R9: mask falls, vectors delivered in ascending order, 2 skipped
        @(negedge clk); fn_mask = 1'b0;
        for (int n = 0; n < NV; n++) begin
            if (n != 2) take_msg(n, "R9 order");
        end
        no_msg("R7 vector mask", 4);
        rd(12'h800, 4'hF, d); chk("R9 pending cleared", 64'(d), 64'h04);

        // R8: clearing the control mask bit delivers vector 2
        wr(12'(2 * 16 + 12), 32'h0, 4'hF);
        take_msg(2, "R8 unmask by write");
        rd(12'h800, 4'hF, d); chk("R8 pending cleared", 64'(d), 64'd0);

        // R5: steady high level does nothing
        no_msg("R5 steady level", 8);
        @(negedge clk); irq_lvl = '0;
        no_msg("R5 low level", 4);

        // R8: pending while disabled, delivered when enable rises
        @(negedge clk); fn_enable = 1'b0; irq_lvl[5] = 1'b1;
        no_msg("R7 disabled again", 4);
        @(negedge clk); fn_enable = 1'b1;
        take_msg(5, "R8 unmask by enable");

        // R6: direct delivery with everything open
        @(negedge clk); irq_lvl[3] = 1'b1;
        take_msg(3, "R6 direct");
        rd(12'h800, 4'hF, d); chk("R9 pending after direct", 64'(d), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule